// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block judges whether a phase-locked loop has settled. For each reference period it measures, in ticks of a fast sampling clock, how far apart the reference strobe and the feedback-divider strobe are. A period is good when that gap is shorter than a programmed tick threshold. The lock flag rises only after a run of good periods of the selected length: three or five. Any bad period cancels the run and drops the flag at once.

Both strobes are one-clock pulses already synchronous to the sampling clock. Either strobe may lead. A period is also bad in three cases: the reference strobe comes twice with no feedback strobe between, the feedback strobe comes twice with no reference strobe between, or the closing strobe never arrives before the tick counter fills. The precision select is a single bit. In a wider setup word it is bit 18.

Top module: `lock_watch`

## Requirements
- R1: While reset is held and after it is released, `locked` is 0 until a qualifying run completes.
- R2: The phase gap is the number of clock cycles from the first strobe to the second, in either order. A period is good only when the gap is strictly less than `tol_ticks`: a gap of `tol_ticks`-1 is good and a gap of `tol_ticks` is bad.
- R3: With `prec_sel` = 0, `locked` becomes 1 on the third consecutive good period and not before.
- R4: With `prec_sel` = 1, `locked` becomes 1 on the fifth consecutive good period and not before.
- R5: A single bad period clears the run count and forces `locked` to 0. A new run then starts from zero.
- R6: A second reference strobe before any feedback strobe counts as a bad period, and that second reference strobe opens a new measurement.
- R7: If the closing strobe has not come when the tick count reaches 2^CNT_W-1, the period is bad and the meter returns to idle.
- R8: `locked` changes only on the second clock edge after the edge that samples the closing strobe (or the timeout). It holds its value in all other cycles.
- R9: Strobes in the same cycle give a gap of 0. That period is good whenever `tol_ticks` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all timing is counted in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe marking a reference edge |
| fb_stb | input | 1 | One-cycle strobe marking a feedback-divider edge |
| prec_sel | input | 1 | 0: run of 3 good periods; 1: run of 5 |
| tol_ticks | input | TOL_W | Tolerance threshold in sampling ticks (strict less-than) |
| locked | output | 1 | Registered lock-detect level |

## Verification
The bench builds the block with CNT_W = 4 and TOL_W = 4, and programs a threshold of 6 ticks. A 4-bit counter fills after 15 ticks, so the timeout of R7 is reached in a short wait. The 6-tick threshold puts both sides of the tolerance boundary (gaps 5 and 6) within a few cycles. The default 10-bit counter would make the timeout take about a thousand cycles per probe.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_WAIT_FB  = 2'd1,
      PH_WAIT_REF = 2'd2
   } ph_state_e;

   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned n;
      n = 1;
      while ((1 << n) <= v) n++;
      return n;
   endfunction
endpackage

// File: rtl/ld_phase_meter.sv
module ld_phase_meter
   import lockdet_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int TOL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_stb,
   input  logic             fb_stb,
   input  logic [TOL_W-1:0] tol_ticks,
   output logic             meas_valid,
   output logic             meas_good
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("ld_phase_meter: CNT_W must be at least 2");
   end
   if (TOL_W > CNT_W) begin : g_bad_tol
      $error("ld_phase_meter: TOL_W must not exceed CNT_W");
   end

   ph_state_e        st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             v_d, g_d;
   logic [CNT_W-1:0] tol_x;
   logic             open_stb, close_stb;

   assign tol_x     = CNT_W'(tol_ticks);
   assign open_stb  = (st_q == PH_WAIT_FB) ? ref_stb : fb_stb;
   assign close_stb = (st_q == PH_WAIT_FB) ? fb_stb  : ref_stb;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      v_d   = 1'b0;
      g_d   = 1'b0;
      case (st_q)
         PH_IDLE: begin
            if (ref_stb && fb_stb) begin
               v_d = 1'b1;
               g_d = (tol_x != '0);
            end else if (ref_stb) begin
               st_d  = PH_WAIT_FB;
               cnt_d = CNT_ONE;
            end else if (fb_stb) begin
               st_d  = PH_WAIT_REF;
               cnt_d = CNT_ONE;
            end
         end
         PH_WAIT_FB, PH_WAIT_REF: begin
            if (close_stb) begin
               v_d = 1'b1;
               g_d = (cnt_q < tol_x);
               if (open_stb) begin
                  cnt_d = CNT_ONE;
               end else begin
                  st_d = PH_IDLE;
               end
            end else if (open_stb) begin
               v_d   = 1'b1;
               cnt_d = CNT_ONE;
            end else if (cnt_q == CNT_MAX) begin
               v_d  = 1'b1;
               st_d = PH_IDLE;
            end else begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         default: st_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= PH_IDLE;
         cnt_q      <= '0;
         meas_valid <= 1'b0;
         meas_good  <= 1'b0;
      end else begin
         st_q       <= st_d;
         cnt_q      <= cnt_d;
         meas_valid <= v_d;
         meas_good  <= g_d;
      end
   end

   // R9: coincident strobes with nonzero threshold give a good result
   assert_same_cycle_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PH_IDLE && ref_stb && fb_stb && tol_ticks != '0) |=> (meas_valid && meas_good));

   // R6: repeated reference strobe while waiting for feedback is bad
   assert_double_ref_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PH_WAIT_FB && ref_stb && !fb_stb) |=> (meas_valid && !meas_good && st_q == PH_WAIT_FB));

   // R7: counter full with no closing strobe ends the period as bad
   assert_timeout_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != PH_IDLE && cnt_q == CNT_MAX && !ref_stb && !fb_stb)
      |=> (meas_valid && !meas_good && st_q == PH_IDLE));

   // R2: a good result never comes from a gap at or above the threshold
   assert_gap_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != PH_IDLE && close_stb && cnt_q >= tol_x) |=> !meas_good);
endmodule

// File: rtl/ld_run_judge.sv
module ld_run_judge #(
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic meas_valid,
   input  logic meas_good,
   input  logic prec_sel,
   output logic locked
);
   localparam int RUN_W = lockdet_pkg::bits_for(LONG_RUN);
   localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(LONG_RUN);

   if (SHORT_RUN < 1 || LONG_RUN < SHORT_RUN) begin : g_bad_run
      $error("ld_run_judge: need 1 <= SHORT_RUN <= LONG_RUN");
   end

   logic [RUN_W-1:0] run_q, run_inc, need;

   assign need    = prec_sel ? RUN_W'(LONG_RUN) : RUN_W'(SHORT_RUN);
   assign run_inc = (run_q == RUN_CAP) ? run_q : run_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         locked <= 1'b0;
      end else if (meas_valid) begin
         if (meas_good) begin
            run_q  <= run_inc;
            locked <= (run_inc >= need);
         end else begin
            run_q  <= '0;
            locked <= 1'b0;
         end
      end
   end

   // R1: reset holds the flag low
   assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !locked);

   // R5: a bad result drops the flag on the next edge
   assert_bad_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !meas_good) |=> (!locked && run_q == '0));

   // R8: no result, no change
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_valid |=> $stable(locked));

   // R3/R4: the flag rises only after a good result with a full run
   assert_rise_on_run_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && meas_good && !locked && run_q + 1'b1 < need) |=> !locked);
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
   parameter int CNT_W     = 10,
   parameter int TOL_W     = 8,
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_stb,
   input  logic             fb_stb,
   input  logic             prec_sel,
   input  logic [TOL_W-1:0] tol_ticks,
   output logic             locked
);
   logic meas_valid, meas_good;

   ld_phase_meter #(.CNT_W(CNT_W), .TOL_W(TOL_W)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_stb    (ref_stb),
      .fb_stb     (fb_stb),
      .tol_ticks  (tol_ticks),
      .meas_valid (meas_valid),
      .meas_good  (meas_good)
   );

   ld_run_judge #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .meas_valid (meas_valid),
      .meas_good  (meas_good),
      .prec_sel   (prec_sel),
      .locked     (locked)
   );
endmodule

// File: tb/sim_lock_watch.sv
module sim_lock_watch;
   localparam int CLK_PERIOD = 10;
   localparam int CW  = 4;
   localparam int TW  = 4;
   localparam int TOL = 6;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0, ref_stb = 1'b0, fb_stb = 1'b0, prec_sel = 1'b0;
   logic [TW-1:0] tol_ticks = TW'(TOL);
   logic locked;

   int checks = 0, errors = 0, run = 0;
   bit done = 0;
   item_t sbq[$];

   lock_watch #(.CNT_W(CW), .TOL_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
      .prec_sel(prec_sel), .tol_ticks(tol_ticks), .locked(locked)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: locked=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic note(input bit good, input string tag);
      item_t it;
      if (good) run = (run < 5) ? run + 1 : 5;
      else run = 0;
      it.exp = (run >= (prec_sel ? 5 : 3));
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // one period: gap d ticks, fb leads when fb_first
   task automatic meas(input int d, input bit fb_first, input string tag);
      @(negedge clk);
      if (d == 0) begin ref_stb = 1; fb_stb = 1; end
      else if (fb_first) fb_stb = 1;
      else ref_stb = 1;
      @(negedge clk);
      ref_stb = 0; fb_stb = 0;
      if (d > 0) begin
         repeat (d - 1) @(negedge clk);
         if (fb_first) ref_stb = 1; else fb_stb = 1;
         @(negedge clk);
         ref_stb = 0; fb_stb = 0;
      end
      @(negedge clk);
      note(d < TOL, tag);
      repeat (2) @(negedge clk);
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         wait (sbq.size() != 0);
         it = sbq.pop_front();
         check(locked, it.exp, it.tag);
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: locked=%0b expected=finish", locked);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      check(locked, 1'b0, "R1 during reset");
      rst_n = 1;
      @(negedge clk);
      check(locked, 1'b0, "R1 after reset");

      // R3: run of three, ref leading
      meas(2, 0, "R3 good 1");
      meas(2, 0, "R3 good 2");
      meas(2, 0, "R3 good 3 locks");
      // R2: fb leading, gap TOL-1 good
      meas(TOL - 1, 1, "R2 fb-first gap tol-1");
      // R2/R5: gap equal to TOL is bad
      meas(TOL, 0, "R2 R5 gap tol bad");
      // R9: coincident strobes
      meas(0, 0, "R9 coincident 1");
      meas(0, 0, "R9 coincident 2");
      meas(0, 0, "R9 coincident 3 locks");

      // R6: second ref before fb
      @(negedge clk); ref_stb = 1;
      @(negedge clk); ref_stb = 0;
      repeat (3) @(negedge clk);
      ref_stb = 1;
      @(negedge clk); ref_stb = 0;
      @(negedge clk);
      note(0, "R6 double ref bad");
      fb_stb = 1;
      @(negedge clk); fb_stb = 0;
      @(negedge clk);
      note(1, "R6 new period from second ref");
      repeat (2) @(negedge clk);

      // R7: timeout after lock
      meas(1, 0, "R5 rerun 2");
      meas(1, 0, "R5 rerun 3 locks");
      @(negedge clk); ref_stb = 1;
      @(negedge clk); ref_stb = 0;
      repeat (18) @(negedge clk);
      note(0, "R7 timeout bad");
      repeat (2) @(negedge clk);

      // R4: run of five
      prec_sel = 1;
      meas(3, 1, "R4 good 1");
      meas(3, 0, "R4 good 2");
      meas(3, 1, "R4 good 3 not yet");
      meas(3, 0, "R4 good 4 not yet");
      meas(3, 0, "R4 good 5 locks");

      // R8: idle cycles leave the flag alone
      for (int i = 0; i < 4; i++) begin
         repeat (3) @(negedge clk);
         check(locked, 1'b1, "R8 hold while idle");
      end
      // R8: flag not yet changed one edge after the closing strobe
      @(negedge clk); ref_stb = 1;
      @(negedge clk); ref_stb = 0;
      repeat (TOL) @(negedge clk);
      fb_stb = 1;
      @(negedge clk); fb_stb = 0;
      check(locked, 1'b1, "R8 one edge after bad close");
      @(negedge clk);
      note(0, "R8 R5 drop two edges after close");
      repeat (3) @(negedge clk);

      wait (sbq.size() == 0);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule